// File: doc/BRIEF.md
# Synchronous Serial Port with Bit-Count Bursts

This block is a clock-generating synchronous serial shifter. A single control write loads a baud divisor, a burst length in bits and a bit order, then starts a burst. The block pulls transmit bytes one at a time through a valid/ready handshake. It shifts each bit out on `sdo` while it shifts the bit on `sdi` into a receive register. A burst can be any length from 1 to 256 bits, so the last byte can be partial.

After every eighth bit the port asks for the next byte. If no byte arrives, it parks the serial clock low and waits. The burst then resumes at the exact bit where it stopped, so a slow byte source acts as a pause at a byte boundary. Received bytes, and a final partial byte, are handed out with a one-cycle strobe. A done flag marks the end of each burst.

Top module: `sync_serial_port`

## Requirements
- R1: A control write while the port is idle latches divisor, length and bit order. On the next cycle `busy` is 1 and `txReady` is 1, and the port waits for the first byte.
- R2: A burst produces exactly as many rising edges of `sclk` as the length field gives (1 to 255). A length field of 0 gives 256 edges.
- R3: With `ctlMsbFirst`=1, each byte goes out bit 7 first down to bit 0. With 0, bit 0 goes out first up to bit 7. `sdo` only changes while `sclk` is low.
- R4: `sdi` is sampled at each rising edge of `sclk`. The first bit sampled in a byte has the highest weight when MSB-first and weight 1 when LSB-first. A final byte of n<8 bits sits in `rxData[n-1:0]` in the same order, and its upper bits are 0.
- R5: With divisor D, `sclk` stays low for D+2 system cycles and high for D+1 cycles. At D=0 the bit period is 3 cycles, 2 low then 1 high.
- R6: After each completed 8 bits, while no new byte is offered, `sclk` stays low, `busy` stays 1 and `txReady` is 1. When a byte is accepted, the burst continues with the next bit and no bit is lost.
- R7: When the last bit's high phase ends, `done` becomes 1 and `busy` becomes 0 on the same cycle. The next control write clears `done`.
- R8: A control write while `busy` is 1 has no effect on the running burst's length, divisor or bit order.
- R9: `rxValid` pulses for one cycle per completed byte and once more for a final partial byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctlWrite | input | 1 | Control write strobe; starts a burst when idle |
| ctlDivisor | input | DIV_W | Baud divisor D |
| ctlLength | input | LEN_W | Burst length in bits, 0 means 256 |
| ctlMsbFirst | input | 1 | 1 = MSB first, 0 = LSB first |
| txData | input | 8 | Next transmit byte |
| txValid | input | 1 | Transmit byte offered |
| txReady | output | 1 | Port is waiting for a byte |
| sclk | output | 1 | Serial clock, idle low |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| rxData | output | 8 | Received byte, right-aligned when partial |
| rxValid | output | 1 | One-cycle strobe for `rxData` |
| busy | output | 1 | Burst in progress |
| done | output | 1 | Last burst completed |

## Verification
The hardest situation to reach is a stall at a byte boundary in the middle of a burst. From the ports it looks the same as a finished burst, except that `busy` stays high and the bit position must survive the wait. The bench feeds bytes from a byte source with a limit it can hold back. It offers only the first byte of a 16-bit burst and checks over 40 cycles that the clock stays parked low. It then releases the second byte and checks that all 16 bits arrive in order on both lines. A 256-bit burst and single-bit and 13-bit bursts drive the length encoding and the partial-byte alignment.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam int SSP_DATA_W = 8;
  localparam int SSP_IDX_W  = $clog2(SSP_DATA_W);

  // strobes from the sequencer into the shift datapath
  typedef struct packed {
    logic                 load;     // take a fresh transmit byte
    logic                 shift;    // advance transmit register (falling edge)
    logic                 sample;   // capture sdi (rising edge)
    logic                 publish;  // byte or final fragment complete
    logic [SSP_IDX_W-1:0] lastIdx;  // index of the bit being sampled
  } sspStrobe_t;
endpackage

// File: rtl/ssp_ctrl.sv
module ssp_ctrl
  import ssp_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctlWrite,
  input  logic [DIV_W-1:0] ctlDivisor,
  input  logic [LEN_W-1:0] ctlLength,
  input  logic             ctlMsbFirst,
  input  logic             txValid,
  output logic             txReady,
  output logic             sclk,
  output logic             busy,
  output logic             done,
  output logic             msbFirst,
  output sspStrobe_t       strobe
);
  localparam int REM_W = LEN_W + 1;
  localparam int CNT_W = DIV_W + 1;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_LOW, S_HIGH} state_t;

  state_t               state;
  logic [DIV_W-1:0]     divReg;
  logic [REM_W-1:0]     remaining;
  logic [SSP_IDX_W-1:0] bitIdx;
  logic [CNT_W-1:0]     phaseCnt;
  logic                 doneReg;
  logic                 msbReg;
  logic                 lastBit, byteEnd, lowEnd, highEnd;

  assign lastBit = (remaining == REM_W'(1));
  assign byteEnd = (bitIdx == SSP_IDX_W'(SSP_DATA_W - 1));
  assign lowEnd  = (state == S_LOW)  && (phaseCnt == CNT_W'(divReg) + CNT_W'(1));
  assign highEnd = (state == S_HIGH) && (phaseCnt == CNT_W'(divReg));

  always_comb begin
    strobe         = '0;
    strobe.load    = (state == S_WAIT) && txValid;
    strobe.sample  = lowEnd;
    strobe.publish = lowEnd && (lastBit || byteEnd);
    strobe.lastIdx = bitIdx;
    strobe.shift   = highEnd && !lastBit && !byteEnd;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      divReg    <= '0;
      remaining <= '0;
      bitIdx    <= '0;
      phaseCnt  <= '0;
      doneReg   <= 1'b0;
      msbReg    <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (ctlWrite) begin
          divReg    <= ctlDivisor;
          msbReg    <= ctlMsbFirst;
          remaining <= (ctlLength == '0) ? {1'b1, {LEN_W{1'b0}}} : {1'b0, ctlLength};
          doneReg   <= 1'b0;
          state     <= S_WAIT;
        end
        S_WAIT: if (txValid) begin
          bitIdx   <= '0;
          phaseCnt <= '0;
          state    <= S_LOW;
        end
        S_LOW: begin
          if (lowEnd) begin
            phaseCnt <= '0;
            state    <= S_HIGH;
          end else begin
            phaseCnt <= phaseCnt + CNT_W'(1);
          end
        end
        S_HIGH: begin
          if (highEnd) begin
            phaseCnt  <= '0;
            remaining <= remaining - REM_W'(1);
            bitIdx    <= bitIdx + SSP_IDX_W'(1);
            if (lastBit) begin
              state   <= S_IDLE;
              doneReg <= 1'b1;
            end else if (byteEnd) begin
              state <= S_WAIT;
            end else begin
              state <= S_LOW;
            end
          end else begin
            phaseCnt <= phaseCnt + CNT_W'(1);
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign txReady  = (state == S_WAIT);
  assign sclk     = (state == S_HIGH);
  assign busy     = (state != S_IDLE);
  assign done     = doneReg;
  assign msbFirst = msbReg;

  // R7: completion coincides with the drop of busy
  a_r7_done_with_idle: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $fell(busy));
  // R8: configuration frozen during a burst
  a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> ($stable(divReg) && $stable(msbReg)));
  // R2: a running burst always has bits left
  a_r2_bits_left: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (remaining != '0));
  // R5: high phase never exceeds the divisor
  a_r5_high_bound: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_HIGH) |-> (phaseCnt <= CNT_W'(divReg)));
  // R6: a waiting port keeps waiting until a byte is offered
  a_r6_stall_holds: assert property (@(posedge clk) disable iff (!rstN)
    (txReady && !txValid) |=> (txReady && !sclk));
endmodule

// File: rtl/ssp_dp.sv
module ssp_dp
  import ssp_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  sspStrobe_t            strobe,
  input  logic                  msbFirst,
  input  logic                  sdi,
  input  logic [SSP_DATA_W-1:0] txData,
  output logic                  sdo,
  output logic [SSP_DATA_W-1:0] rxData,
  output logic                  rxValid
);
  logic [SSP_DATA_W-1:0] txShift, rxShift, rxNext;

  assign sdo    = msbFirst ? txShift[SSP_DATA_W-1] : txShift[0];
  assign rxNext = msbFirst ? {rxShift[SSP_DATA_W-2:0], sdi}
                           : {sdi, rxShift[SSP_DATA_W-1:1]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      rxData  <= '0;
      rxValid <= 1'b0;
    end else begin
      rxValid <= strobe.publish;
      if (strobe.load) begin
        txShift <= txData;
        rxShift <= '0;
      end else if (strobe.shift) begin
        txShift <= msbFirst ? (txShift << 1) : (txShift >> 1);
      end
      if (strobe.sample) rxShift <= rxNext;
      if (strobe.publish)
        rxData <= msbFirst ? rxNext
                           : (rxNext >> (SSP_DATA_W - 1 - int'(strobe.lastIdx)));
    end
  end

  // R9: one strobe per byte, never back to back
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);
  // R4: a published byte always follows a sample
  a_r4_after_sample: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> $past(strobe.sample));
endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port
  import ssp_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int LEN_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  ctlWrite,
  input  logic [DIV_W-1:0]      ctlDivisor,
  input  logic [LEN_W-1:0]      ctlLength,
  input  logic                  ctlMsbFirst,
  input  logic [SSP_DATA_W-1:0] txData,
  input  logic                  txValid,
  output logic                  txReady,
  output logic                  sclk,
  output logic                  sdo,
  input  logic                  sdi,
  output logic [SSP_DATA_W-1:0] rxData,
  output logic                  rxValid,
  output logic                  busy,
  output logic                  done
);
  sspStrobe_t strobe;
  logic       msbFirst;

  ssp_ctrl #(.DIV_W(DIV_W), .LEN_W(LEN_W)) uCtrl (
    .clk, .rstN, .ctlWrite, .ctlDivisor, .ctlLength, .ctlMsbFirst,
    .txValid, .txReady, .sclk, .busy, .done, .msbFirst, .strobe
  );

  ssp_dp uDp (
    .clk, .rstN, .strobe, .msbFirst, .sdi, .txData, .sdo, .rxData, .rxValid
  );

  // R3: data out is steady across a high phase
  a_r3_sdo_steady_high: assert property (@(posedge clk) disable iff (!rstN)
    (sclk && $past(sclk)) |-> $stable(sdo));
endmodule

// File: tb/tb_sync_serial_port.sv
`timescale 1ns/1ps
module tb_sync_serial_port;
  logic       clk = 0, rstN = 0;
  logic       ctlWrite = 0, ctlMsbFirst = 0;
  logic [7:0] ctlDivisor = 0, ctlLength = 0;
  logic [7:0] txData = 0;
  logic       txValid = 0, sdi = 0;
  logic       txReady, sclk, sdo, rxValid, busy, done;
  logic [7:0] rxData;

  sync_serial_port dut (.*);

  always #2 clk = ~clk;

  int compared = 0, mismatched = 0;
  logic [7:0] txMem [32];
  logic       sdiBits [256];
  logic       txBits [256];
  int         riseCyc [256];
  logic [7:0] rxGot [40];
  int riseCount = 0, rxCount = 0, feedIdx = 0, feedLimit = 0;
  int cyc = 0, lastHigh = 0;
  logic sclkPrev = 0, hsPrev = 0;

  task automatic chk(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // serial slave model, byte source and receive monitor
  always @(negedge clk) begin
    cyc++;
    if (sclk && !sclkPrev) begin
      if (riseCount < 256) begin
        txBits[riseCount]  = sdo;
        riseCyc[riseCount] = cyc;
      end
      riseCount++;
    end
    if (!sclk && sclkPrev && riseCount > 0 && riseCount <= 256)
      lastHigh = cyc - riseCyc[riseCount-1];
    sclkPrev = sclk;
    sdi = sdiBits[riseCount % 256];
    if (rxValid && rxCount < 40) begin
      rxGot[rxCount] = rxData;
      rxCount++;
    end
    if (hsPrev) feedIdx++;
    hsPrev  = txValid && txReady;
    txValid = (feedIdx < feedLimit);
    txData  = txMem[feedIdx % 32];
  end

  task automatic prepare(int seed, int limit);
    @(negedge clk);
    for (int j = 0; j < 32; j++) txMem[j] = 8'((j * 37 + seed * 11 + 5) & 255);
    for (int k = 0; k < 256; k++) sdiBits[k] = (((k * 7 + seed) % 5) < 2);
    riseCount = 0; rxCount = 0; feedIdx = 0; hsPrev = 0; feedLimit = limit;
  endtask

  task automatic startBurst(int len, int div, bit msb);
    @(negedge clk);
    ctlWrite = 1; ctlLength = 8'(len); ctlDivisor = 8'(div); ctlMsbFirst = msb;
    @(negedge clk);
    ctlWrite = 0;
    chk("R1 busy after start", busy, 1);
    chk("R1 txReady after start", txReady, 1);
    chk("R7 done cleared by start", done, 0);
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic verifyBurst(int len, int div, bit msb);
    int bad = 0;
    int nBytes = (len + 7) / 8;
    chk("R2 rising edge count", riseCount, len);
    for (int k = 0; k < len; k++) begin
      logic [7:0] b = txMem[k / 8];
      if (txBits[k] !== b[msb ? 7 - (k % 8) : (k % 8)]) bad++;
    end
    chk("R3 sdo bit errors", bad, 0);
    chk("R9 rx strobe count", rxCount, nBytes);
    for (int j = 0; j < nBytes && j < rxCount; j++) begin
      int n = (len - 8 * j < 8) ? len - 8 * j : 8;
      logic [7:0] e = 0;
      for (int i = 0; i < n; i++) e[msb ? n - 1 - i : i] = sdiBits[8 * j + i];
      chk("R4 rx byte", rxGot[j], e);
    end
    if (len >= 2) chk("R5 bit period", riseCyc[1] - riseCyc[0], 2 * div + 3);
    chk("R5 high width", lastHigh, div + 1);
    chk("R7 done at end", done, 1);
    chk("R7 busy at end", busy, 0);
  endtask

  task automatic testReset();
    chk("R1 reset busy", busy, 0);
    chk("R7 reset done", done, 0);
    chk("R5 reset sclk", sclk, 0);
    chk("R6 reset txReady", txReady, 0);
  endtask

  task automatic testBurst(int seed, int len, int div, bit msb);
    int eff = (len == 0) ? 256 : len;
    prepare(seed, 32);
    startBurst(len, div, msb);
    waitIdle();
    verifyBurst(eff, div, msb);
  endtask

  task automatic testStall();
    prepare(9, 1);
    startBurst(16, 1, 1);
    for (int i = 0; i < 2000 && !(riseCount == 8 && txReady); i++) @(negedge clk);
    for (int i = 0; i < 40; i++) begin
      if (sclk || !busy || !txReady) begin
        chk("R6 parked during stall", 0, 1);
        break;
      end
      @(negedge clk);
    end
    chk("R6 edges before resume", riseCount, 8);
    feedLimit = 2;
    waitIdle();
    verifyBurst(16, 1, 1);
  endtask

  task automatic testIgnoredWrite();
    prepare(4, 32);
    startBurst(8, 2, 1);
    for (int i = 0; i < 2000 && riseCount < 3; i++) @(negedge clk);
    ctlWrite = 1; ctlLength = 8'd3; ctlDivisor = 8'd0; ctlMsbFirst = 0;
    @(negedge clk);
    ctlWrite = 0;
    waitIdle();
    verifyBurst(8, 2, 1);   // R8: original settings kept
  endtask

  initial begin
    #(4 * 150000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testBurst(1, 16, 0, 1);   // minimum divider, 2-then-1 pattern
    testBurst(2, 13, 3, 0);   // LSB first, partial final byte
    testBurst(3, 0, 0, 1);    // length code 0 = 256 bits
    testBurst(5, 1, 0, 0);    // single bit
    testBurst(6, 21, 4, 1);   // MSB first, partial final byte
    testStall();
    testIgnoredWrite();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule